// File: doc/BRIEF.md
# Memory-Mapped IDE Register Adapter

This adapter lets a processor bus without a dedicated disk controller talk to an ATA task-file device. The bus fabric gives it two window selects. The primary window reaches the 16-bit data port and the 8-bit task-file registers. The secondary window reaches the alternate status register on reads and the device control register on writes. The adapter shifts the bus address right by a fixed stride (`SHIFT`) before it picks a register. Boards that wire the device to wider address steps can therefore use it unchanged.

Each accepted bus request becomes one registered cycle toward the device. In that cycle the adapter drives one chip select, one read or write strobe, a 3-bit register number and the write data. Read data comes back in that same cycle together with a valid flag. The adapter keeps a local copy of the device control byte. Bit 1 of that copy masks the interrupt passed to the processor. Bit 2 holds the device in reset.

Top module: `mmio_ide_adapter`

## Requirements
- R1: After reset, no chip select or strobe is active, the register number and write data are zero, `dev_rst` is low, and `irq_out` follows `dev_intrq`.
- R2: A primary-window request in cycle T gives, in cycle T+1, `dev_cs0` high and `dev_reg` equal to bits [2:0] of `bus_addr >> SHIFT`. Address bits below `SHIFT` are ignored. If both windows are selected, the primary window wins.
- R3: In the primary window, a register number of 0 (index & 7 == 0) is the 16-bit data port: writes pass `bus_wdata[15:0]`, and reads return `dev_rdata[15:0]` zero-extended. Any other index is a byte register: writes put `bus_wdata[7:0]` out with `dev_wdata[15:8]` = 0, and reads return `dev_rdata[7:0]` with all upper bits zero.
- R4: A secondary-window read gives `dev_cs1` with `dev_reg` = 6 and a read strobe. It returns `dev_rdata[7:0]` zero-extended and leaves the stored control byte unchanged.
- R5: A secondary-window write gives `dev_cs1` with `dev_reg` = 6 and a write strobe carrying the low data byte. It stores that byte as the control byte from the next cycle on.
- R6: `irq_out` = `dev_intrq` AND NOT (control byte bit 1).
- R7: `dev_rst` equals control byte bit 2.
- R8: `bus_size` (0 byte, 1 halfword, 2 word) has no effect on any output.
- R9: A cycle with no window selected, or with neither `bus_rd` nor `bus_wr`, gives no chip select and no strobe in the next cycle. Each request gives a single one-cycle strobe. If `bus_rd` and `bus_wr` are both high, the request is a write.
- R10: `bus_rvalid` is high in exactly the cycles where `dev_rd` is high. Otherwise `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address within the selected window |
| bus_size | input | 2 | Access size, accepted and ignored |
| bus_pri_sel | input | 1 | Primary window select |
| bus_sec_sel | input | 1 | Secondary window select |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | BW | Write data |
| bus_rdata | output | BW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| dev_cs0 | output | 1 | Task-file chip select |
| dev_cs1 | output | 1 | Control-block chip select |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_reg | output | 3 | Device register number |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data |
| dev_intrq | input | 1 | Device interrupt request |
| dev_rst | output | 1 | Device reset (control bit 2) |
| irq_out | output | 1 | Masked interrupt to the processor |

## Verification
The embedded assertions check these properties on every cycle:
- the chip selects are mutually exclusive, and so are the read and write strobes;
- an idle cycle produces no strobe;
- a primary request decodes its register number from the shifted address;
- a secondary access always targets register 6;
- byte-register reads carry no upper bits;
- the effect of a control write on the reset and mask outputs.

Only the bench's scenarios can show the rest:
- the full register sweep, including the mirror of index 8 onto the data port;
- junk in the address bits below the stride;
- the rule that the primary window wins when both are selected;
- write priority when both strobes are requested;
- the invariance to access size;
- that an alternate-status read leaves the control state untouched.

// File: rtl/mmio_ide_adapter.sv
module mmio_ide_adapter #(
  parameter int SHIFT = 1,
  parameter int AW    = 8,
  parameter int BW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_pri_sel,
  input  logic          bus_sec_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          dev_cs0,
  output logic          dev_cs1,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [2:0]    dev_reg,
  output logic [15:0]   dev_wdata,
  input  logic [15:0]   dev_rdata,
  input  logic          dev_intrq,
  output logic          dev_rst,
  output logic          irq_out
);
  localparam int        IDX_LO  = SHIFT;
  localparam int        IDX_HI  = SHIFT + 2;
  localparam logic [2:0] CTL_REG = 3'd6;

  logic [2:0] idx;
  logic       any_req, go_pri, go_sec, go, pri_data;
  logic       data_q;
  logic [7:0] ctl_q;
  logic       unused_bits;

  assign idx      = bus_addr[IDX_HI:IDX_LO];
  assign any_req  = bus_rd | bus_wr;
  assign go_pri   = bus_pri_sel & any_req;
  assign go_sec   = bus_sec_sel & ~bus_pri_sel & any_req;
  assign go       = go_pri | go_sec;
  assign pri_data = go_pri & (idx == 3'd0);

  assign unused_bits = ^{bus_size, bus_addr, bus_wdata[BW-1:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_cs0   <= 1'b0;
      dev_cs1   <= 1'b0;
      dev_rd    <= 1'b0;
      dev_wr    <= 1'b0;
      dev_reg   <= 3'd0;
      dev_wdata <= 16'd0;
      data_q    <= 1'b0;
      ctl_q     <= 8'd0;
    end else begin
      dev_cs0 <= go_pri;
      dev_cs1 <= go_sec;
      dev_wr  <= go & bus_wr;
      dev_rd  <= go & bus_rd & ~bus_wr;
      data_q  <= pri_data;
      if (go_pri)      dev_reg <= idx;
      else if (go_sec) dev_reg <= CTL_REG;
      else             dev_reg <= 3'd0;
      if (!go)           dev_wdata <= 16'd0;
      else if (pri_data) dev_wdata <= bus_wdata[15:0];
      else               dev_wdata <= {8'd0, bus_wdata[7:0]};
      if (go_sec && bus_wr) ctl_q <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (dev_rd) begin
      if (data_q) bus_rdata[15:0] = dev_rdata;
      else        bus_rdata[7:0]  = dev_rdata[7:0];
    end
  end

  assign bus_rvalid = dev_rd;
  assign dev_rst    = ctl_q[2];
  assign irq_out    = dev_intrq & ~ctl_q[1];

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_cs0 && dev_cs1)); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_pri_sel || bus_sec_sel) && (bus_rd || bus_wr))
      |=> !(dev_rd || dev_wr || dev_cs0 || dev_cs1)); // R9
  AST_PRI_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_pri_sel && (bus_rd || bus_wr))
      |=> (dev_cs0 && dev_reg == $past(bus_addr[IDX_HI:IDX_LO]))); // R2
  AST_SEC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cs1 |-> (dev_reg == CTL_REG)); // R4
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && dev_reg != 3'd0) |-> (bus_rdata[BW-1:8] == '0)); // R3
  AST_NIEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sec_sel && !bus_pri_sel && bus_wr && bus_wdata[1]) |=> !irq_out); // R6
  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sec_sel && !bus_pri_sel && bus_wr && bus_wdata[2]) |=> dev_rst); // R7
endmodule

// File: tb/mmio_ide_adapter_bench.sv
module mmio_ide_adapter_bench;
  localparam int SH = 1;
  localparam int AW = 8;
  localparam int BW = 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic bus_pri_sel = 0, bus_sec_sel = 0, bus_rd = 0, bus_wr = 0;
  logic [BW-1:0] bus_wdata = 0;
  logic [BW-1:0] bus_rdata;
  logic bus_rvalid, dev_cs0, dev_cs1, dev_rd, dev_wr, dev_rst, irq_out;
  logic [2:0] dev_reg;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = 16'hACE1;
  logic dev_intrq = 0;

  mmio_ide_adapter #(.SHIFT(SH), .AW(AW), .BW(BW)) u_mmio_ide_adapter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_pri_sel(bus_pri_sel), .bus_sec_sel(bus_sec_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dev_cs0(dev_cs0), .dev_cs1(dev_cs1),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_reg(dev_reg),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_intrq(dev_intrq),
    .dev_rst(dev_rst), .irq_out(irq_out));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h at t=%0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_cs0, m_cs1, m_rd, m_wr, m_data;
  int m_reg, m_wd, m_ctl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cs0 = 0; m_cs1 = 0; m_rd = 0; m_wr = 0; m_data = 0;
      m_reg = 0; m_wd = 0; m_ctl = 0;
    end else begin
      bit gp, gs;
      int ix;
      gp = bus_pri_sel && (bus_rd || bus_wr);
      gs = bus_sec_sel && !bus_pri_sel && (bus_rd || bus_wr);
      ix = (int'(bus_addr) >> SH) % 8;
      m_cs0 = gp; m_cs1 = gs;
      m_wr = (gp || gs) && bus_wr;
      m_rd = (gp || gs) && bus_rd && !bus_wr;
      m_data = gp && ix == 0;
      m_reg = gp ? ix : (gs ? 6 : 0);
      m_wd = !(gp || gs) ? 0 : (m_data ? int'(bus_wdata[15:0]) : int'(bus_wdata[7:0]));
      if (gs && bus_wr) m_ctl = int'(bus_wdata[7:0]);
    end
  end

  always @(negedge clk) begin
    dev_rdata <= {dev_rdata[14:0], dev_rdata[15] ^ dev_rdata[13] ^ dev_rdata[12] ^ dev_rdata[10]};
    #1;
    if (rst_n && !done) begin
      int er;
      er = !m_rd ? 0 : (m_data ? int'(dev_rdata) : int'(dev_rdata[7:0]));
      chk("R2 cs0", dev_cs0, m_cs0);
      chk("R2 reg", dev_reg, m_reg);
      chk("R4 cs1", dev_cs1, m_cs1);
      chk("R9 rd", dev_rd, m_rd);
      chk("R9 wr", dev_wr, m_wr);
      chk("R3 wdata", dev_wdata, m_wd);
      chk("R10 rvalid", bus_rvalid, m_rd);
      chk("R3 rdata", bus_rdata, er);
      chk("R6 irq", irq_out, dev_intrq && !m_ctl[1]);
      chk("R7 rst", dev_rst, m_ctl[2]);
    end
  end

  task automatic req(bit p, bit s, bit r, bit w, int a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_pri_sel = p; bus_sec_sel = s; bus_rd = r; bus_wr = w;
    bus_addr = a[AW-1:0]; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_pri_sel = 0; bus_sec_sel = 0; bus_rd = 0; bus_wr = 0;
    #2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: got=%0d expected<=50000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    dev_intrq = 1;
    #35;
    chk("R1 cs0", dev_cs0, 0); chk("R1 cs1", dev_cs1, 0);
    chk("R1 strobes", {dev_rd, dev_wr}, 0); chk("R1 reg", dev_reg, 0);
    chk("R1 wdata", dev_wdata, 0); chk("R1 rst", dev_rst, 0);
    chk("R1 irq", irq_out, 1);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 16; i++) req(1, 0, 0, 1, i << SH, 32'hCAFE_0000 | (i * 32'h1111), 2);
    for (int i = 0; i < 16; i++) req(1, 0, 1, 0, (i << SH) | 1, 0, 1);
    req(1, 0, 0, 1, 8 << SH, 32'h0000_5AA5, 0);
    chk("R3 mirror data", dev_wdata, 16'h5AA5);
    req(1, 0, 0, 1, 3 << SH, 32'h0000_5AA5, 0);
    chk("R3 byte wdata", dev_wdata, 16'h00A5);
    req(1, 1, 1, 0, 5 << SH, 0, 2);
    chk("R2 pri wins", {dev_cs0, dev_cs1}, 2'b10);
    req(1, 0, 1, 1, 2 << SH, 32'h77, 2);
    chk("R9 write wins", {dev_rd, dev_wr}, 2'b01);
    req(0, 0, 1, 1, 0, 32'hFF, 2);
    chk("R9 no select", {dev_cs0, dev_cs1, dev_rd, dev_wr}, 0);
    req(1, 0, 0, 0, 0, 32'hFF, 2);
    chk("R9 no strobe", {dev_cs0, dev_rd, dev_wr}, 0);
    req(0, 1, 0, 1, 0, 32'h0000_0004, 2);
    chk("R5 ctl write", {dev_cs1, dev_reg, dev_wdata[7:0]}, {1'b1, 3'd6, 8'h04});
    @(negedge clk); #2;
    chk("R5 srst stored", dev_rst, 1);
    req(0, 1, 1, 0, 3, 0, 0);
    chk("R4 alt status read", {dev_cs1, dev_rd, dev_reg}, {1'b1, 1'b1, 3'd6});
    chk("R4 rdata zext", bus_rdata[31:8], 0);
    @(negedge clk); #2;
    chk("R4 ctl kept", dev_rst, 1);
    req(0, 1, 0, 1, 0, 32'h0000_0002, 1);
    @(negedge clk); #2;
    chk("R6 masked", irq_out, 0);
    chk("R7 released", dev_rst, 0);
    dev_intrq = 0; @(negedge clk); #2;
    req(0, 1, 0, 1, 0, 0, 0);
    dev_intrq = 1; @(negedge clk); #2;
    chk("R6 unmasked", irq_out, 1);
    for (int sz = 0; sz < 3; sz++) begin
      req(1, 0, 0, 1, 0, 32'h1234_BEEF, sz[1:0]);
      chk("R8 size ignored", dev_wdata, 16'hBEEF);
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bus_pri_sel = i[0]; bus_sec_sel = i[1]; bus_rd = i[2]; bus_wr = (i % 5) == 0;
      bus_addr = AW'(i * 7); bus_wdata = 32'h9E37_79B9 * i; bus_size = i[1:0];
      dev_intrq = i[3];
    end
    @(negedge clk); bus_pri_sel = 0; bus_sec_sel = 0; bus_rd = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    #3;
    finish_run();
  end
endmodule